// File: doc/BRIEF.md
# Byte-Wide Serial Peripheral Master with Collision Detection

This block is a serial peripheral interface master that moves one byte at a time in both directions. Software drives it through four byte-wide registers on a simple synchronous bus: one holds the byte to send and returns the byte received, one picks the clock polarity, the clock phase and a clock rate, one chooses which of the active-low select lines is driven low, and one reports and clears flags. Writing the data register while the controller is idle starts an exchange. The controller then produces sixteen serial clock edges, shifts the outgoing byte out on `mosi` MSB first, and collects eight bits from `miso`.

The select line stays under software control and does not change between bytes. A multi-byte transaction is therefore a sequence of data writes with one select line held low throughout. Different peripherals can use different modes and rates: software rewrites the mode register between transactions. Mode and select writes made during an exchange are dropped, so a running byte cannot be disturbed. A data write during an exchange is also dropped, and it raises a sticky collision flag.

Register offsets on `bus_addr`: 0 = data, 1 = mode, 2 = select, 3 = status. The read data on `bus_rdata` is combinational from `bus_addr`.

Top module: `spi_byte_master`

## Requirements
- R1: After reset all select outputs are high, `sclk` and `mosi` are low, and the data, mode and status registers all read zero.
- R2: A data-register write while idle starts a full-duplex exchange of 8 bits MSB first. Afterwards the peripheral has received the written byte, and a read at offset 0 returns the 8 bits sampled from `miso`.
- R3: Whenever no exchange runs, `sclk` sits at mode bit 0 (CPOL): low for 0 and high for 1.
- R4: Mode bit 1 (CPHA) = 0 means bit 7 is on `mosi` before the first `sclk` edge, bits are sampled on leading edges and changed on trailing edges. CPHA = 1 means bits change on leading edges and are sampled on trailing edges.
- R5: Mode bits 3:2 select the rate r, with one `sclk` period equal to 2^(r+1) system clocks. An exchange keeps the busy flag high for exactly 16·2^r cycles.
- R6: Select register bit 7 enables and bits 2:0 give the index. The enabled index drives only its own `cs_n` bit low. An index at or above the number of select lines, or bit 7 clear, leaves every `cs_n` bit high.
- R7: Writes to the mode or select register during an exchange have no effect on the mode readback, on `cs_n` or on the exchange.
- R8: A data-register write during an exchange sets the collision flag (status bit 1). The running exchange still sends the original byte.
- R9: Status bit 2 is high during an exchange. Status bit 0 (done) is set when the exchange ends and is cleared by a read at offset 0.
- R10: Writing the status register with bit 1 set clears the collision flag.
- R11: When an exchange ends in the same cycle as a data-register read, the done flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (read side effects) |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to peripheral |
| miso | input | 1 | Serial data from peripheral |
| cs_n | output | 4 | Active-low select lines, one per peripheral |

## Verification
The end of an exchange sets the done flag. A read of the data register clears it. These two can land on the same clock edge. The bench counts the edges from the starting write and places a data read on exactly the edge that produces the sixteenth `sclk` transition, then requires the done flag to read back set. A later plain read then has to clear it. A mid-exchange data write is also placed among live serial edges, and the peripheral model must still receive the first byte.

// File: rtl/spim_pkg.sv
package spim_pkg;

  localparam int RATE_W = 2;
  localparam int CNT_W  = (1 << RATE_W) - 1;

  typedef enum logic [1:0] {
    OFS_DATA = 2'd0,
    OFS_MODE = 2'd1,
    OFS_SEL  = 2'd2,
    OFS_STAT = 2'd3
  } reg_ofs_e;

  typedef struct packed {
    logic [RATE_W-1:0] rate;
    logic              cpha;
    logic              cpol;
  } mode_t;

  // last count value of one half period of sclk, i.e. 2^rate - 1
  function automatic logic [CNT_W-1:0] half_last(input logic [RATE_W-1:0] rate);
    logic [CNT_W:0] one;
    one = {{CNT_W{1'b0}}, 1'b1};
    return CNT_W'((one << rate) - 1'b1);
  endfunction

  // even edge numbers are leading edges; data is sampled on leading
  // edges when cpha is 0 and on trailing edges when cpha is 1
  function automatic logic is_sample_edge(input logic k_lsb, input logic cpha);
    return k_lsb == cpha;
  endfunction

endpackage

// File: rtl/spim_clkgen.sv
module spim_clkgen
  import spim_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [RATE_W-1:0] rate,
  output logic              edge_stb
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;

  assign lim      = half_last(rate);
  assign edge_stb = run && (cnt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (!run)     cnt <= '0;
    else if (edge_stb) cnt <= '0;
    else               cnt <= cnt + 1'b1;
  end

  // R5: the half-period counter never passes its limit while running
  a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> cnt <= lim);

  // R5: edges are spaced by a full half period
  a_r5_edge_gap: assert property (@(posedge clk) disable iff (!rst_n)
    edge_stb && lim != '0 |=> !edge_stb);

endmodule

// File: rtl/spim_engine.sv
module spim_engine
  import spim_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] load_byte,
  input  logic          cpol,
  input  logic          cpha,
  input  logic          edge_stb,
  input  logic          miso,
  output logic          busy,
  output logic          sclk,
  output logic          mosi,
  output logic [DW-1:0] rx_byte,
  output logic          xfer_end
);

  localparam int EDGES = 2 * DW;
  localparam int K_W   = $clog2(EDGES);
  localparam logic [K_W-1:0] K_LAST = K_W'(EDGES - 1);

  logic [K_W-1:0] k;
  logic           sclk_q;
  logic [DW-1:0]  tx_sr;
  logic [DW-1:0]  rx_sr;
  logic           sample_now;
  logic           shift_now;

  assign xfer_end   = busy && edge_stb && (k == K_LAST);
  assign sample_now = busy && edge_stb && is_sample_edge(k[0], cpha);
  assign shift_now  = busy && edge_stb && !is_sample_edge(k[0], cpha)
                      && (k != '0) && (k != K_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      k      <= '0;
      sclk_q <= 1'b0;
      tx_sr  <= '0;
      rx_sr  <= '0;
    end else if (start && !busy) begin
      busy   <= 1'b1;
      k      <= '0;
      sclk_q <= cpol;
      tx_sr  <= load_byte;
    end else if (busy && edge_stb) begin
      sclk_q <= ~sclk_q;
      k      <= k + 1'b1;
      if (sample_now) rx_sr <= {rx_sr[DW-2:0], miso};
      if (shift_now)  tx_sr <= {tx_sr[DW-2:0], 1'b0};
      if (xfer_end)   busy  <= 1'b0;
    end
  end

  assign sclk    = busy ? sclk_q : cpol;
  assign mosi    = tx_sr[DW-1];
  assign rx_byte = rx_sr;

  // R3: after the final edge the clock has toggled back to its idle level
  a_r3_end_at_idle: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_end |-> sclk_q != cpol);

  // R4: mosi does not move across a sampling edge
  a_r4_mosi_steady: assert property (@(posedge clk) disable iff (!rst_n)
    sample_now |=> $stable(mosi));

  // R2: the exchange stops after its last edge
  a_r2_end_idle: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_end |=> !busy);

endmodule

// File: rtl/spim_regs.sv
module spim_regs
  import spim_pkg::*;
#(
  parameter int DW     = 8,
  parameter int NUM_CS = 4,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              busy,
  input  logic              xfer_end,
  input  logic [DW-1:0]     rx_byte,
  output logic              start,
  output logic              coll_evt,
  output mode_t             mode,
  output logic [NUM_CS-1:0] cs_n
);

  localparam int MODE_W = $bits(mode_t);

  logic             wr_data, wr_mode, wr_sel, wr_stat, rd_data;
  logic             done_q, coll_q;
  logic             sel_en;
  logic [IDX_W-1:0] sel_idx;

  assign wr_data = bus_wr && (bus_addr == OFS_DATA);
  assign wr_mode = bus_wr && (bus_addr == OFS_MODE);
  assign wr_sel  = bus_wr && (bus_addr == OFS_SEL);
  assign wr_stat = bus_wr && (bus_addr == OFS_STAT);
  assign rd_data = bus_rd && (bus_addr == OFS_DATA);

  assign start    = wr_data && !busy;
  assign coll_evt = wr_data && busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode    <= '0;
      sel_en  <= 1'b0;
      sel_idx <= '0;
    end else if (!busy) begin
      if (wr_mode) mode <= mode_t'(bus_wdata[MODE_W-1:0]);
      if (wr_sel) begin
        sel_en  <= bus_wdata[DW-1];
        sel_idx <= bus_wdata[IDX_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        done_q <= 1'b0;
    else if (xfer_end) done_q <= 1'b1;
    else if (rd_data)  done_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      coll_q <= 1'b0;
    else if (coll_evt)               coll_q <= 1'b1;
    else if (wr_stat && bus_wdata[1]) coll_q <= 1'b0;
  end

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign cs_n[i] = !(sel_en && (sel_idx == IDX_W'(i)));
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_DATA: bus_rdata = rx_byte;
      OFS_MODE: bus_rdata[MODE_W-1:0] = mode;
      OFS_SEL: begin
        bus_rdata[DW-1]      = sel_en;
        bus_rdata[IDX_W-1:0] = sel_idx;
      end
      default: bus_rdata[2:0] = {busy, coll_q, done_q};
    endcase
  end

  // R8: a data write during an exchange leaves the collision flag set
  a_r8_coll_set: assert property (@(posedge clk) disable iff (!rst_n)
    coll_evt |=> coll_q);

  // R7: mode is frozen while an exchange runs
  a_r7_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(mode));

  // R9, R11: end of exchange always leaves done set
  a_r11_done_wins: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_end |=> done_q);

endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
  import spim_pkg::*;
#(
  parameter int DW     = 8,
  parameter int NUM_CS = 4,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [NUM_CS-1:0] cs_n
);

  logic          start_go;
  logic          coll_evt;
  logic          edge_stb;
  logic          xfer_end;
  logic          busy;
  logic [DW-1:0] rx_byte;
  mode_t         mode;

  spim_regs #(.DW(DW), .NUM_CS(NUM_CS), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .busy(busy), .xfer_end(xfer_end), .rx_byte(rx_byte),
    .start(start_go), .coll_evt(coll_evt), .mode(mode), .cs_n(cs_n)
  );

  spim_clkgen u_clk (
    .clk(clk), .rst_n(rst_n), .run(busy), .rate(mode.rate),
    .edge_stb(edge_stb)
  );

  spim_engine #(.DW(DW)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(start_go), .load_byte(bus_wdata),
    .cpol(mode.cpol), .cpha(mode.cpha), .edge_stb(edge_stb), .miso(miso),
    .busy(busy), .sclk(sclk), .mosi(mosi), .rx_byte(rx_byte),
    .xfer_end(xfer_end)
  );

  // R6: never more than one select line low
  a_r6_cs_single: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  // R7: select lines hold still during an exchange
  a_r7_cs_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(cs_n));

  // R2: an exchange only begins from an accepted idle data write
  a_r2_start_src: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start_go));

  // R8: a colliding write never restarts the running exchange
  a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    coll_evt |=> busy || $past(xfer_end));

endmodule

// File: tb/sim_spi_byte_master.sv
module sim_spi_byte_master;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [1:0] bus_addr = 2'd3;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       sclk, mosi;
  logic       miso = 1'b0;
  logic [3:0] cs_n;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  spi_byte_master u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  // {cpol, cpha, rate[1:0], idx[2:0], pad, master byte, peripheral byte}
  localparam logic [23:0] VECS [6] = '{
    {1'b0, 1'b0, 2'd0, 3'd0, 1'b0, 8'hA5, 8'h3C},
    {1'b0, 1'b1, 2'd1, 3'd1, 1'b0, 8'h81, 8'hC3},
    {1'b1, 1'b0, 2'd2, 3'd2, 1'b0, 8'h5A, 8'h0F},
    {1'b1, 1'b1, 2'd3, 3'd3, 1'b0, 8'hFF, 8'h00},
    {1'b0, 1'b0, 2'd1, 3'd2, 1'b0, 8'h00, 8'hFF},
    {1'b1, 1'b1, 2'd0, 3'd1, 1'b0, 8'h6E, 8'h91}
  };

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual !== expected) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, actual, expected);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 2'd3;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0; bus_addr = 2'd3;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
    bus_addr = 2'd3;
  endtask

  // starts an exchange and plays the peripheral; optional bus access at
  // loop iteration inj_at (iteration c is captured on the c-th edge after start)
  task automatic run_xfer(input logic [7:0] tx, input logic [7:0] sb,
                          input logic cpha, input int inj_at,
                          input logic inj_wr, input logic inj_rd,
                          input logic [1:0] inj_addr, input logic [7:0] inj_data,
                          output int cyc, output logic [7:0] srx);
    logic [7:0] s_sh;
    logic [7:0] st;
    logic       prev;
    int         edges;
    s_sh = sb; srx = 8'h00; miso = sb[7];
    bus_write(2'd0, tx);
    peek(2'd3, st);
    check("R9 busy during exchange", int'(st[2]), 1);
    if (!cpha) check("R4 first bit before first edge", int'(mosi), int'(tx[7]));
    prev = sclk; edges = 0; cyc = 0;
    while (edges < 16 && cyc < 2000) begin
      cyc++;
      if (cyc == inj_at) begin
        bus_wr = inj_wr; bus_rd = inj_rd; bus_addr = inj_addr; bus_wdata = inj_data;
      end else if (cyc == inj_at + 1) begin
        bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = 2'd3;
      end
      @(negedge clk);
      if (sclk != prev) begin
        prev = sclk;
        if ((edges % 2) == 0) begin
          if (!cpha) srx = {srx[6:0], mosi};
          else begin miso = s_sh[7]; s_sh = {s_sh[6:0], 1'b0}; end
        end else begin
          if (cpha) srx = {srx[6:0], mosi};
          else begin s_sh = {s_sh[6:0], 1'b0}; miso = s_sh[7]; end
        end
        edges++;
      end
    end
    bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = 2'd3;
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    logic [7:0] srx;
    int         cyc;

    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 cs_n in reset", int'(cs_n), 4'hF);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 cs_n", int'(cs_n), 4'hF);
    check("R1 sclk", int'(sclk), 0);
    check("R1 mosi", int'(mosi), 0);
    peek(2'd3, rd); check("R1 status", int'(rd), 0);
    peek(2'd1, rd); check("R1 mode", int'(rd), 0);
    peek(2'd0, rd); check("R1 data", int'(rd), 0);

    // table of modes, rates, selects and byte patterns
    for (int i = 0; i < 6; i++) begin
      logic       vpol, vpha;
      logic [1:0] vrate;
      logic [2:0] vidx;
      logic [7:0] vtx, vsb;
      {vpol, vpha, vrate, vidx} = VECS[i][23:17];
      vtx = VECS[i][15:8];
      vsb = VECS[i][7:0];
      bus_write(2'd1, {4'b0, vrate, vpha, vpol});
      bus_write(2'd2, {1'b1, 4'b0, vidx});
      check("R6 one select low", int'(cs_n), int'(~(4'b1 << vidx) & 4'hF));
      check("R3 idle level before", int'(sclk), int'(vpol));
      run_xfer(vtx, vsb, vpha, 0, 1'b0, 1'b0, 2'd3, 8'h00, cyc, srx);
      check("R5 busy length", cyc, 16 << vrate);
      check("R2 peripheral got byte", int'(srx), int'(vtx));
      check("R3 idle level after", int'(sclk), int'(vpol));
      peek(2'd3, rd);
      check("R9 done set, busy clear", int'(rd), 1);
      bus_read(2'd0, rd);
      check("R2 received byte", int'(rd), int'(vsb));
      peek(2'd3, rd);
      check("R9 done cleared by data read", int'(rd), 0);
    end

    // R6: out-of-range index and disabled select
    bus_write(2'd2, 8'h85);
    check("R6 index beyond lines", int'(cs_n), 4'hF);
    bus_write(2'd2, 8'h02);
    check("R6 enable clear", int'(cs_n), 4'hF);

    // R8: collision during a slow exchange
    bus_write(2'd1, 8'h08);
    bus_write(2'd2, 8'h80);
    run_xfer(8'hC6, 8'h2B, 1'b0, 5, 1'b1, 1'b0, 2'd0, 8'h39, cyc, srx);
    check("R8 original byte sent", int'(srx), 8'hC6);
    peek(2'd3, rd);
    check("R8 collision and done", int'(rd), 3);
    bus_read(2'd0, rd);
    check("R8 received byte intact", int'(rd), 8'h2B);
    bus_write(2'd3, 8'h02);
    peek(2'd3, rd);
    check("R10 collision cleared", int'(rd), 0);

    // R7: mode write during exchange ignored
    run_xfer(8'h12, 8'h34, 1'b0, 7, 1'b1, 1'b0, 2'd1, 8'h03, cyc, srx);
    peek(2'd1, rd);
    check("R7 mode unchanged", int'(rd), 8'h08);
    check("R7 exchange unaffected", int'(srx), 8'h12);
    check("R7 idle level unchanged", int'(sclk), 0);
    bus_read(2'd0, rd);

    // R7: select write during exchange ignored
    run_xfer(8'h77, 8'h88, 1'b0, 9, 1'b1, 1'b0, 2'd2, 8'h82, cyc, srx);
    check("R7 cs_n unchanged", int'(cs_n), 4'hE);
    peek(2'd2, rd);
    check("R7 select readback", int'(rd), 8'h80);
    bus_read(2'd0, rd);

    // R11: data read on the very edge that ends the exchange (rate 0)
    bus_write(2'd1, 8'h00);
    peek(2'd3, rd);
    check("R11 done clear beforehand", int'(rd[0]), 0);
    run_xfer(8'h4D, 8'hB2, 1'b0, 16, 1'b0, 1'b1, 2'd0, 8'h00, cyc, srx);
    peek(2'd3, rd);
    check("R11 done survives same-cycle read", int'(rd), 1);
    bus_read(2'd0, rd);
    check("R11 received byte", int'(rd), 8'hB2);
    peek(2'd3, rd);
    check("R9 later read clears done", int'(rd), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule